// File: doc/BRIEF.md
# Bit-Slice Selectable Arithmetic/Logic/Shift Unit

This block is a W-bit datapath unit that runs one of fourteen operations on two operands A and B. A four-bit select code picks the operation. A carry input either feeds the adder or is ignored, depending on the operation. Internally the unit is a chain of identical one-bit slices. Each slice holds a full adder whose second input comes from a four-way operand picker, a small logic function and the shift taps from its neighbours. A final per-slice selector picks which of these drives the bit. The carry leaving each slice enters the next one, and the lowest slice takes the carry input.

The select code splits into a group field, sel[3:2], and a function field, sel[1:0]. In the arithmetic group the adder computes A + Y + cin. Here Y is zero, B, the bitwise complement of B or all ones, chosen by sel[1:0]. As a result, cin acts as a third function bit that picks among eight arithmetic results. The result and the carry out are captured in output registers on the rising clock edge, so a new result appears one cycle after its inputs are applied.

Top module: `sel_alu`

## Requirements
- R1: While rst is high at a rising edge of clk, f and cout are both 0 after that edge (synchronous, active-high reset).
- R2: The inputs present at a rising edge (rst low) decide f and cout after that edge. The latency is one clock.
- R3: With sel[3:2]=00, f = (A + Y + cin) mod 2^W. Y is all zeros for sel[1:0]=00, B for 01, ~B for 10 and all ones for 11. This gives pass A, A+1, A+B, A+B+1, A+~B, A−B, A−1 and pass A for {sel[1:0],cin} = 000 through 111.
- R4: With sel[3:2]=00, cout equals bit W of the full sum A + Y + cin.
- R5: With sel[3:2]=01, f is A AND B for sel[1:0]=00, A OR B for 01, A XOR B for 10 and NOT A for 11.
- R6: In the logic and shift groups (sel[3:2] not 00), the value of cin has no effect on f or cout.
- R7: With sel[3:2]=10, f is A shifted right by one bit, with 0 entering the top bit, whatever sel[1:0] is.
- R8: With sel[3:2]=11, f is A shifted left by one bit, with 0 entering the bottom bit, whatever sel[1:0] is.
- R9: Outside the arithmetic group, cout is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| a | input | W | First operand |
| b | input | W | Second operand |
| sel | input | 4 | Operation select: [3:2] group, [1:0] function |
| cin | input | 1 | Carry into the lowest slice (arithmetic only) |
| f | output | W | Registered result |
| cout | output | 1 | Registered carry out of the top slice |

## Verification
The outputs hold no state beyond one registered result, so any internal fault shows at f or cout on the cycle right after the inputs that expose it. A broken link in the carry chain or a wrong operand-picker leg corrupts only those arithmetic codes and operand values that propagate a carry through the faulty slice. For this reason the bench sweeps all 32 combinations of select and carry over edge operands such as all ones, the sign boundary and alternating bits. A wrong neighbour tap or end fill shows in the top or bottom bit of a shift result.

// File: rtl/sel_alu_pkg.sv
package sel_alu_pkg;
  typedef enum logic [1:0] {
    GRP_ARITH = 2'b00,
    GRP_LOGIC = 2'b01,
    GRP_SHR   = 2'b10,
    GRP_SHL   = 2'b11
  } grp_e;

  typedef enum logic [1:0] {
    YSEL_ZERO = 2'b00,
    YSEL_B    = 2'b01,
    YSEL_NB   = 2'b10,
    YSEL_ONES = 2'b11
  } ysel_e;
endpackage

// File: rtl/sel_alu_slice.sv
module sel_alu_slice
  import sel_alu_pkg::*;
(
  input  logic       a_bit,
  input  logic       b_bit,
  input  logic       a_upper,
  input  logic       a_lower,
  input  logic [3:0] sel,
  input  logic       c_in,
  output logic       c_out,
  output logic       f_bit
);
  logic y_bit;
  logic sum_bit;
  logic lg_bit;
  logic half;

  always_comb begin
    unique case (ysel_e'(sel[1:0]))
      YSEL_ZERO: y_bit = 1'b0;
      YSEL_B:    y_bit = b_bit;
      YSEL_NB:   y_bit = ~b_bit;
      default:   y_bit = 1'b1;
    endcase
  end

  assign half    = a_bit ^ y_bit;
  assign sum_bit = half ^ c_in;
  assign c_out   = (a_bit & y_bit) | (half & c_in);

  always_comb begin
    unique case (sel[1:0])
      2'b00:   lg_bit = a_bit & b_bit;
      2'b01:   lg_bit = a_bit | b_bit;
      2'b10:   lg_bit = a_bit ^ b_bit;
      default: lg_bit = ~a_bit;
    endcase
  end

  always_comb begin
    unique case (grp_e'(sel[3:2]))
      GRP_ARITH: f_bit = sum_bit;
      GRP_LOGIC: f_bit = lg_bit;
      GRP_SHR:   f_bit = a_upper;
      default:   f_bit = a_lower;
    endcase
  end
endmodule

// File: rtl/sel_alu_outreg.sv
module sel_alu_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_f,
  input  logic         d_co,
  output logic [W-1:0] q_f,
  output logic         q_co
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_f  <= '0;
      q_co <= 1'b0;
    end else begin
      q_f  <= d_f;
      q_co <= d_co;
    end
  end
endmodule

// File: rtl/sel_alu.sv
module sel_alu
  import sel_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   sel,
  input  logic         cin,
  output logic [W-1:0] f,
  output logic         cout
);
  localparam int MSB = W - 1;

  logic [W:0]   carry;
  logic [W-1:0] f_comb;
  logic [W-1:0] up_tap;
  logic [W-1:0] lo_tap;
  logic         co_comb;

  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_slice
    if (i == MSB) begin : g_top
      assign up_tap[i] = 1'b0;
    end else begin : g_mid_up
      assign up_tap[i] = a[i+1];
    end
    if (i == 0) begin : g_bot
      assign lo_tap[i] = 1'b0;
    end else begin : g_mid_lo
      assign lo_tap[i] = a[i-1];
    end

    sel_alu_slice u_slice (
      .a_bit   (a[i]),
      .b_bit   (b[i]),
      .a_upper (up_tap[i]),
      .a_lower (lo_tap[i]),
      .sel     (sel),
      .c_in    (carry[i]),
      .c_out   (carry[i+1]),
      .f_bit   (f_comb[i])
    );
  end

  assign co_comb = (grp_e'(sel[3:2]) == GRP_ARITH) ? carry[W] : 1'b0;

  sel_alu_outreg #(.W(W)) u_outreg (
    .clk  (clk),
    .rst  (rst),
    .d_f  (f_comb),
    .d_co (co_comb),
    .q_f  (f),
    .q_co (cout)
  );
endmodule

// File: rtl/sel_alu_chk.sv
module sel_alu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [3:0]   sel,
  input logic         cin,
  input logic [W-1:0] f,
  input logic         cout
);
  // R1
  p_reset_r1: assert property (@(posedge clk) rst |=> (f == '0 && cout == 1'b0));

  // R3: pass-through code with zero carry gives A back
  p_pass_r3: assert property (@(posedge clk) disable iff (rst)
    ({sel, cin} == 5'b00000) |=> (f == $past(a) && cout == 1'b0));

  // R5: AND code
  p_and_r5: assert property (@(posedge clk) disable iff (rst)
    (sel == 4'b0100) |=> (f == ($past(a) & $past(b))));

  // R7
  p_shr_r7: assert property (@(posedge clk) disable iff (rst)
    (sel[3:2] == 2'b10) |=> (f == ($past(a) >> 1)));

  // R8
  p_shl_r8: assert property (@(posedge clk) disable iff (rst)
    (sel[3:2] == 2'b11) |=> (f == ($past(a) << 1)));

  // R9
  p_nocarry_r9: assert property (@(posedge clk) disable iff (rst)
    (sel[3:2] != 2'b00) |=> (cout == 1'b0));
endmodule

bind sel_alu sel_alu_chk #(.W(W)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .a    (a),
  .b    (b),
  .sel  (sel),
  .cin  (cin),
  .f    (f),
  .cout (cout)
);

// File: tb/sel_alu_bench.sv
module sel_alu_bench;
  localparam int W = 8;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic [3:0]   sel = '0;
  logic         cin = 1'b0;
  logic [W-1:0] f;
  logic         cout;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int exp_f[$];
  int exp_c[$];
  string exp_tag[$];
  string exp_ctag[$];

  always #2 clk = ~clk;

  sel_alu #(.W(W)) u_sel_alu (
    .clk(clk), .rst(rst), .a(a), .b(b), .sel(sel), .cin(cin), .f(f), .cout(cout)
  );

  function automatic int model(input int av, input int bv, input int s, input int c);
    int y, full;
    case ((s >> 2) & 3)
      0: begin
        case (s & 3)
          0: y = 0;
          1: y = bv;
          2: y = (~bv) & MASK;
          default: y = MASK;
        endcase
        full = av + y + c;
        return full & ((MASK << 1) | 1);
      end
      1: begin
        case (s & 3)
          0: return av & bv;
          1: return av | bv;
          2: return av ^ bv;
          default: return (~av) & MASK;
        endcase
      end
      2: return av >> 1;
      default: return (av << 1) & MASK;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Each compare happens one clock after its inputs were driven (R2).
  task automatic compare_pending();
    if (exp_f.size() > 0) begin
      check({exp_tag.pop_front(), " f (R2 latency)"}, int'(f), exp_f.pop_front());
      check({exp_ctag.pop_front(), " cout (R2 latency)"}, int'(cout), exp_c.pop_front());
    end
  endtask

  task automatic step(input int av, input int bv, input int s, input int c);
    int r;
    string t, ct;
    @(negedge clk);
    compare_pending();
    a = av[W-1:0]; b = bv[W-1:0]; sel = s[3:0]; cin = c[0];
    r = model(av & MASK, bv & MASK, s, c);
    case ((s >> 2) & 3)
      0: begin t = "R3"; ct = "R4"; end
      1: begin t = (c != 0) ? "R6" : "R5"; ct = (c != 0) ? "R6" : "R9"; end
      2: begin t = (c != 0) ? "R6" : "R7"; ct = "R9"; end
      default: begin t = (c != 0) ? "R6" : "R8"; ct = "R9"; end
    endcase
    exp_f.push_back(r & MASK);
    exp_c.push_back((r >> W) & 1);
    exp_tag.push_back(t);
    exp_ctag.push_back(ct);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int corners[7] = '{0, MASK, 8'h80, 8'h7F, 1, 8'h55, 8'hAA};
    // R1: reset with inputs that would otherwise give nonzero outputs
    a = '1; b = '1; sel = 4'b0001; cin = 1'b1; rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 f", int'(f), 0);
    check("R1 cout", int'(cout), 0);
    rst = 1'b0;

    for (int s = 0; s < 16; s++)
      for (int c = 0; c < 2; c++)
        for (int i = 0; i < 7; i++)
          for (int j = 0; j < 7; j++)
            step(corners[i], corners[j], s, c);

    for (int k = 0; k < 3000; k++)
      step($urandom & MASK, $urandom & MASK, $urandom & 15, $urandom & 1);

    // R1: reset mid-stream clears a nonzero result
    step(MASK, MASK, 4'b0001, 0);
    @(negedge clk);
    compare_pending();
    rst = 1'b1;
    @(negedge clk);
    check("R1 f mid", int'(f), 0);
    check("R1 cout mid", int'(cout), 0);
    rst = 1'b0;

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule